// File: doc/BRIEF.md
# Weighted Constant-Matrix Row Streamer

The block forms a 10x10 result matrix from a vector of five signed 8-bit samples. Each sample weights one of five fixed 10x10 coefficient matrices, and the five weighted matrices are summed. The result leaves the block one row per output beat. Each beat carries ten 12-bit elements, together with the row number and an end-of-matrix flag.

Ten column lanes are shared by all ten rows. In each lane, five multipliers feed a saturating 16-bit accumulator, and a rounding stage narrows the sum to 12 bits. The input side holds two vectors: one being emitted and one waiting. An upstream source can therefore run continuously, and the rows of consecutive vectors follow each other with no idle cycle, provided the source keeps up.

Top module: `cmw_row_streamer`

## Requirements
- R1: An input vector is taken on a clock edge where `in_valid` and `in_ready` are both high. Sample i (i = 0..4) is the signed two's-complement byte at `in_data[8i+7:8i]`.
- R2: The coefficient for sample i, row r, column c (all zero-based) is the signed 8-bit value ((29i + 11r + 5c + 3rc) mod 256) - 128.
- R3: For each output element, the products x_i * C_i[r][c] are added in order i = 0 to 4 into a 16-bit signed accumulator that starts at 0. The accumulator clamps to [-32768, 32767] after every addition.
- R4: The 16-bit sum is narrowed by adding 8 and shifting right arithmetically by 4. The result is then clamped to [-2048, 2047].
- R5: In each beat, column c sits at `out_data[12c+11:12c]`. `out_row` gives the row, in the range 0..9, and `out_last` is high exactly when `out_row` is 9.
- R6: For each vector the rows leave in order 0 to 9, one per accepted beat. All ten rows of a vector leave before any row of the next vector.
- R7: The block holds up to two vectors. `in_ready` is low exactly when two are held. `out_valid` is high in every cycle in which at least one vector is held.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_row` and `out_last` keep their values into the next cycle, and `out_valid` stays high.
- R9: Synchronous active-high `rst` empties both vector slots and sets the row index to 0. After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take a vector |
| in_data | input | 40 | Five signed 8-bit samples |
| out_valid | output | 1 | Row beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 120 | Ten signed 12-bit row elements |
| out_row | output | 4 | Row index of the beat |
| out_last | output | 1 | Beat is row 9 |

## Verification
If the row counter is off or the slot hand-over is wrong, the next accepted beat shows a wrong row index, wrong data or a missing `out_last`. A lost or doubled vector is also caught at the next beat, because every beat is compared with the vector expected at that position in the stream. A slot-occupancy fault shows in the same cycle, as `in_ready` or `out_valid` disagreeing with the number of vectors the bench has handed in but not yet seen complete. Errors in the lanes or the coefficient table appear in the row that uses the affected element. The test vectors include full-scale patterns that drive both the accumulator clamp and the 12-bit clamp.

// File: rtl/cmw_pkg.sv
package cmw_pkg;

    localparam int N_TERMS   = 5;
    localparam int SAMPLE_W  = 8;
    localparam int COEF_W    = 8;
    localparam int ACC_W     = 16;
    localparam int ELEM_W    = 12;
    localparam int N_ROWS    = 10;
    localparam int N_COLS    = 10;
    localparam int NARROW_SH = 4;
    localparam int ROW_W     = $clog2(N_ROWS);
    localparam int IN_WORD_W  = N_TERMS * SAMPLE_W;
    localparam int OUT_WORD_W = N_COLS * ELEM_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef sample_t [N_TERMS-1:0]      vec_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef coef_t [N_TERMS-1:0]        coef_set_t;
    typedef coef_set_t [N_COLS-1:0]     coef_row_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [ELEM_W-1:0]   elem_t;
    typedef logic [ROW_W-1:0]           row_idx_t;

    typedef struct packed {
        logic valid;
        vec_t data;
    } slot_t;

    // Table entry: (29*term + 11*row + 5*col + 3*row*col) mod 2^W, offset by -2^(W-1)
    function automatic coef_t coef_at(input int term, input int row, input int col);
        int v;
        logic [COEF_W-1:0] b;
        v = 29 * term + 11 * row + 5 * col + 3 * row * col;
        b = COEF_W'(v);
        b[COEF_W-1] = ~b[COEF_W-1];
        return coef_t'(b);
    endfunction

    function automatic acc_t sat_add(input acc_t a, input acc_t b);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        return s[ACC_W-1:0];
    endfunction

    function automatic elem_t narrow(input acc_t a);
        logic signed [ACC_W:0] t;
        logic signed [ACC_W:0] hi;
        logic signed [ACC_W:0] lo;
        hi = (ACC_W+1)'((1 << (ELEM_W-1)) - 1);
        lo = -hi - 1;
        t = {a[ACC_W-1], a} + (ACC_W+1)'(1 << (NARROW_SH-1));
        t = t >>> NARROW_SH;
        if (t > hi) return elem_t'(hi[ELEM_W-1:0]);
        if (t < lo) return elem_t'(lo[ELEM_W-1:0]);
        return t[ELEM_W-1:0];
    endfunction

endpackage

// File: rtl/cmw_coef_rom.sv
module cmw_coef_rom
    import cmw_pkg::*;
(
    input  row_idx_t  row_idx,
    output coef_row_t row_coefs
);
    generate
        for (genvar c = 0; c < N_COLS; c++) begin : g_col
            for (genvar i = 0; i < N_TERMS; i++) begin : g_term
                assign row_coefs[c][i] = coef_at(i, int'(row_idx), c);
            end
        end
    endgenerate
endmodule

// File: rtl/cmw_mac_lane.sv
module cmw_mac_lane
    import cmw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vec_t      x,
    input  coef_set_t k,
    output elem_t     y
);
    acc_t sum;

    always_comb begin
        acc_t prod;
        sum = '0;
        for (int i = 0; i < N_TERMS; i++) begin
            prod = ACC_W'($signed(x[i]) * $signed(k[i]));
            sum  = sat_add(sum, prod);
        end
    end

    assign y = narrow(sum);

    // narrowing keeps the sign of the wide sum
    p_sign_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (sum >= 0) |-> (y >= 0))
        else $error("narrowed element changed sign");
endmodule

// File: rtl/cmw_in_buf.sv
module cmw_in_buf
    import cmw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  vec_t  in_vec,
    output logic  in_ready,
    input  logic  take,
    output slot_t cur
);
    slot_t nxt;
    logic  in_fire;

    assign in_ready = !nxt.valid;
    assign in_fire  = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            nxt <= '0;
        end else if (!cur.valid) begin
            if (in_fire) cur <= '{valid: 1'b1, data: in_vec};
        end else if (take) begin
            if (nxt.valid) begin
                cur       <= nxt;
                nxt.valid <= 1'b0;
            end else if (in_fire) begin
                cur <= '{valid: 1'b1, data: in_vec};
            end else begin
                cur.valid <= 1'b0;
            end
        end else if (in_fire) begin
            nxt <= '{valid: 1'b1, data: in_vec};
        end
    end

    p_no_orphan_r7: assert property (@(posedge clk) disable iff (rst)
        nxt.valid |-> cur.valid)
        else $error("waiting slot full while active slot empty");

    p_refill_r7: assert property (@(posedge clk) disable iff (rst)
        (take && nxt.valid) |=> (cur.valid && !nxt.valid))
        else $error("waiting vector not promoted");
endmodule

// File: rtl/cmw_row_streamer.sv
module cmw_row_streamer
    import cmw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [IN_WORD_W-1:0]  in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [OUT_WORD_W-1:0] out_data,
    output logic [ROW_W-1:0]      out_row,
    output logic                  out_last
);
    slot_t     cur;
    row_idx_t  row;
    coef_row_t coefs;
    elem_t     lane_y [N_COLS];
    logic      beat_fire;
    logic      at_last;

    assign at_last   = (row == row_idx_t'(N_ROWS - 1));
    assign beat_fire = cur.valid && out_ready;

    cmw_in_buf u_buf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_vec   (vec_t'(in_data)),
        .in_ready (in_ready),
        .take     (beat_fire && at_last),
        .cur      (cur)
    );

    always_ff @(posedge clk) begin
        if (rst)            row <= '0;
        else if (beat_fire) row <= at_last ? '0 : row + 1'b1;
    end

    cmw_coef_rom u_rom (
        .row_idx   (row),
        .row_coefs (coefs)
    );

    generate
        for (genvar c = 0; c < N_COLS; c++) begin : g_lane
            cmw_mac_lane u_lane (
                .clk (clk),
                .rst (rst),
                .x   (cur.data),
                .k   (coefs[c]),
                .y   (lane_y[c])
            );
            assign out_data[c*ELEM_W +: ELEM_W] = lane_y[c];
        end
    endgenerate

    assign out_valid = cur.valid;
    assign out_row   = row;
    assign out_last  = at_last;

    p_full_means_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid)
        else $error("input stalled with nothing to emit");

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_row)))
        else $error("beat changed while stalled");

    p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_valid && out_row == $past(out_row) + 1'b1))
        else $error("row did not advance by one");

    p_row_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (out_row == '0))
        else $error("row did not return to zero");

    p_row_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_row < row_idx_t'(N_ROWS))
        else $error("row index out of range");
endmodule

// File: tb/sim_cmw_row_streamer.sv
module sim_cmw_row_streamer;
    localparam int CLK_PERIOD = 10;
    localparam int NV    = 24;
    localparam int SPLIT = 12;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [39:0]  in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [119:0] out_data;
    logic [3:0]   out_row;
    logic         out_last;

    int checks = 0;
    int fails  = 0;
    int xs [NV][5];
    int acc_cnt = 0;
    int done_cnt = 0;
    int rcnt = 0;
    int cyc = 0;
    bit choppy = 1'b0;
    bit hold_seen = 1'b0;
    logic [119:0] hold_data;
    logic [3:0]   hold_row;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmw_row_streamer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_row(out_row), .out_last(out_last)
    );

    function automatic int coef(int i, int r, int c);
        return ((29*i + 11*r + 5*c + 3*r*c) % 256) - 128;
    endfunction

    function automatic int elem(int k, int r, int c);
        int acc = 0;
        int t;
        for (int i = 0; i < 5; i++) begin
            acc = acc + xs[k][i] * coef(i, r, c);
            if (acc > 32767) acc = 32767;
            if (acc < -32768) acc = -32768;
        end
        t = (acc + 8) >>> 4;
        if (t > 2047) t = 2047;
        if (t < -2048) t = -2048;
        return t;
    endfunction

    function automatic logic [119:0] exp_row(int k, int r);
        logic [119:0] w;
        for (int c = 0; c < 10; c++) w[12*c +: 12] = 12'(elem(k, r, c));
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= choppy ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
        if (!rst) begin
            if (in_valid && in_ready) acc_cnt <= acc_cnt + 1;
            if (out_valid && out_ready) begin
                if (rcnt == 9) begin
                    rcnt <= 0;
                    done_cnt <= done_cnt + 1;
                end else begin
                    rcnt <= rcnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            // R7: occupancy and no-gap
            check(in_ready == ((acc_cnt - done_cnt) < 2), "R7 in_ready", 128'(in_ready), 128'((acc_cnt - done_cnt) < 2));
            check(out_valid == ((acc_cnt - done_cnt) > 0), "R7 out_valid", 128'(out_valid), 128'((acc_cnt - done_cnt) > 0));
            // R8: stall stability
            if (hold_seen) begin
                check(out_valid && out_data == hold_data && out_row == hold_row,
                      "R8 held beat", {out_valid, out_row, out_data}, {1'b1, hold_row, hold_data});
            end
            hold_seen = out_valid && !out_ready;
            hold_data = out_data;
            hold_row  = out_row;
            if (out_valid && out_ready && done_cnt < NV) begin
                // R1 R2 R3 R4 R5 data, R5 R6 row and last
                check(out_data == exp_row(done_cnt, rcnt), "R3/R4 row data",
                      128'(out_data), 128'(exp_row(done_cnt, rcnt)));
                check(out_row == 4'(rcnt), "R6 row order", 128'(out_row), 128'(rcnt));
                check(out_last == (rcnt == 9), "R5 last flag", 128'(out_last), 128'(rcnt == 9));
            end
        end
    end

    task automatic push(int k);
        logic [39:0] w;
        for (int i = 0; i < 5; i++) w[8*i +: 8] = 8'(xs[k][i]);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] st = 32'h1234_5678;
        for (int k = 0; k < NV; k++) begin
            for (int i = 0; i < 5; i++) begin
                case (k)
                    0: xs[k][i] = 0;
                    1: xs[k][i] = 127;
                    2: xs[k][i] = -128;
                    3: xs[k][i] = (i % 2) ? -128 : 127;
                    4, 5, 6, 7, 8: xs[k][i] = (i == k - 4) ? 1 : 0;
                    9: xs[k][i] = (i == 2) ? -1 : 0;
                    default: begin
                        st = st * 32'd1103515245 + 32'd12345;
                        xs[k][i] = int'($signed(st[23:16]));
                    end
                endcase
            end
        end
        repeat (3) @(negedge clk);
        // R9 reset state
        check(out_valid == 1'b0, "R9 out_valid in reset", 128'(out_valid), 128'(0));
        check(in_ready == 1'b1, "R9 in_ready in reset", 128'(in_ready), 128'(1));
        rst = 1'b0;
        @(negedge clk);
        check(out_row == 4'd0, "R9 row after reset", 128'(out_row), 128'(0));
        check(out_valid == 1'b0, "R9 empty after reset", 128'(out_valid), 128'(0));
        // back-to-back stream, downstream always ready (R7 no gap)
        for (int k = 0; k < SPLIT; k++) push(k);
        in_valid = 1'b0;
        while (done_cnt < SPLIT) @(negedge clk);
        // stalling downstream and idle gaps upstream (R8)
        choppy = 1'b1;
        for (int k = SPLIT; k < NV; k++) begin
            push(k);
            in_valid = 1'b0;
            repeat (k % 4) @(negedge clk);
        end
        while (done_cnt < NV) @(negedge clk);
        repeat (3) @(negedge clk);
        check(done_cnt == NV, "R6 all vectors emitted", 128'(done_cnt), 128'(NV));
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d vectors", done_cnt, NV);
        finish_run();
    end
endmodule